// File: doc/BRIEF.md
# Banked Three-Operand Register File

This block holds the architectural registers of a core whose operand encoding reaches 72 physical registers with 15 bits. Storage is split into eight banks of eight registers each, plus eight shared base registers. An instruction gives one 3-bit bank number and three 4-bit specifiers: a destination and two sources. The top bit of each specifier sends that operand to the base group. Otherwise the operand goes to the register of that index in the bank named by the instruction.

The base registers can be reached under any bank number. Software therefore moves a value from one bank to another in two steps: it copies the value into a base register under the first bank, then copies it out under the second. There are two combinational read ports and one write port that commits on the clock edge. All three operands use the same bank number.

The operand fields come in one of two ways, chosen by a plain select pin. They can arrive on separate bank and specifier pins, or as one packed 15-bit word. Every pin is plain control or data with no handshake. Reads are combinational and a write commits on the edge, so no back-pressure exists and none is modelled.

Top module: `banked_rf`

## Requirements
- R1: A synchronous active-high reset clears all 72 registers to zero. After reset, every register reads zero on both read ports.
- R2: In a specifier, bit 3 = 1 selects base register bits[2:0], which is physical index 64 + bits[2:0]. Bit 3 = 0 selects register bits[2:0] of the current bank, which is physical index bank*8 + bits[2:0].
- R3: A base register holds a single value that is the same under every bank number. A value written to a base register under one bank reads back under any other bank.
- R4: One bank number applies to every banked operand of an operation. A banked source refers to the same bank as a banked destination in the same operation.
- R5: When wr_en is high at a rising clock edge, wr_data is stored into the register selected by the destination specifier. When wr_en is low, no register changes.
- R6: The read ports are combinational. A read of the register being written in the same cycle returns the value held before that edge.
- R7: When use_packed is 1, the operands are taken from op_word, and the separate bank and specifier pins are ignored. The op_word layout is bank [14:12], destination [11:8], source A [7:4], source B [3:0].
- R8: The two read ports are independent. Both ports may name the same register, and each returns that register's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| use_packed | input | 1 | 1 takes operands from op_word, 0 takes them from the separate pins |
| op_word | input | 15 | Packed bank, destination and two source specifiers |
| bank_sel | input | 3 | Bank number when separate pins are used |
| dst_spec | input | 4 | Destination specifier when separate pins are used |
| src_a_spec | input | 4 | Source A specifier when separate pins are used |
| src_b_spec | input | 4 | Source B specifier when separate pins are used |
| wr_en | input | 1 | Write enable |
| wr_data | input | 32 | Data to write |
| rd_a_data | output | 32 | Source A register value |
| rd_b_data | output | 32 | Source B register value |

## Verification
The assertions assume that reset is applied in the first cycles and that the operand inputs are known (never X) whenever reset is low. They also assume that the 3-bit bank field needs no range check, because eight banks fill its code space. The stimulus holds every input at a defined value from time zero. Random operations draw all fields uniformly, so every bank, every specifier and both operand sources occur. When packed mode is active, the unused separate pins carry unrelated random values, so the ignored source is exercised as well.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
  typedef enum int {
    OPND_DST   = 0,
    OPND_SRC_A = 1,
    OPND_SRC_B = 2
  } opnd_role_e;

  localparam int OPND_CNT = 3;
endpackage

// File: rtl/rf_operand_map.sv
module rf_operand_map #(
  parameter int BANK_CNT  = 8,
  parameter int BANK_REGS = 8,
  localparam int BANK_W   = $clog2(BANK_CNT),
  localparam int IDX_W    = $clog2(BANK_REGS),
  localparam int SPEC_W   = IDX_W + 1,
  localparam int PHYS     = BANK_CNT * BANK_REGS + BANK_REGS,
  localparam int PHYS_W   = $clog2(PHYS)
) (
  input  logic [BANK_W-1:0] bank,
  input  logic [SPEC_W-1:0] spec,
  output logic [PHYS_W-1:0] phys
);
  localparam int BANKED_TOTAL = BANK_CNT * BANK_REGS;

  logic [IDX_W-1:0] idx;
  logic             to_base;

  assign idx     = spec[IDX_W-1:0];
  assign to_base = spec[SPEC_W-1];

  always_comb begin
    if (to_base)
      phys = PHYS_W'(BANKED_TOTAL) + PHYS_W'(idx);
    else
      phys = PHYS_W'({bank, idx});
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int DATA_W = 32,
  parameter int PHYS   = 72,
  localparam int PHYS_W = $clog2(PHYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PHYS_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PHYS_W-1:0] rd_a_idx,
  input  logic [PHYS_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data
);
  logic [PHYS-1:0][DATA_W-1:0] regs;

  always_ff @(posedge clk) begin
    if (rst)
      regs <= '0;
    else if (wr_en && (int'(wr_idx) < PHYS))
      regs[wr_idx] <= wr_data;
  end

  always_comb begin
    rd_a_data = (int'(rd_a_idx) < PHYS) ? regs[rd_a_idx] : '0;
    rd_b_data = (int'(rd_b_idx) < PHYS) ? regs[rd_b_idx] : '0;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (regs == '0))
    else $error("reset did not clear storage");

  assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (regs[$past(wr_idx)] == $past(wr_data)))
    else $error("write data not stored");

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(regs))
    else $error("storage changed without write enable");
endmodule

// File: rtl/banked_rf.sv
module banked_rf
  import banked_rf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BANK_CNT  = 8,
  parameter int BANK_REGS = 8,
  localparam int BANK_W   = $clog2(BANK_CNT),
  localparam int IDX_W    = $clog2(BANK_REGS),
  localparam int SPEC_W   = IDX_W + 1,
  localparam int OP_W     = BANK_W + OPND_CNT * SPEC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              use_packed,
  input  logic [OP_W-1:0]   op_word,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [SPEC_W-1:0] dst_spec,
  input  logic [SPEC_W-1:0] src_a_spec,
  input  logic [SPEC_W-1:0] src_b_spec,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data
);
  localparam int BANKED_TOTAL = BANK_CNT * BANK_REGS;
  localparam int PHYS         = BANKED_TOTAL + BANK_REGS;
  localparam int PHYS_W       = $clog2(PHYS);

  logic [BANK_W-1:0]                bank;
  logic [OPND_CNT-1:0][SPEC_W-1:0]  specs;
  logic [OPND_CNT-1:0][PHYS_W-1:0]  phys;

  // packed layout: bank on top, then destination, source A, source B
  always_comb begin
    if (use_packed) begin
      bank              = op_word[OP_W-1 -: BANK_W];
      specs[OPND_DST]   = op_word[3*SPEC_W-1 -: SPEC_W];
      specs[OPND_SRC_A] = op_word[2*SPEC_W-1 -: SPEC_W];
      specs[OPND_SRC_B] = op_word[SPEC_W-1 -: SPEC_W];
    end else begin
      bank              = bank_sel;
      specs[OPND_DST]   = dst_spec;
      specs[OPND_SRC_A] = src_a_spec;
      specs[OPND_SRC_B] = src_b_spec;
    end
  end

  for (genvar g = 0; g < OPND_CNT; g++) begin : g_map
    rf_operand_map #(
      .BANK_CNT  (BANK_CNT),
      .BANK_REGS (BANK_REGS)
    ) u_map (
      .bank (bank),
      .spec (specs[g]),
      .phys (phys[g])
    );
  end

  rf_storage #(
    .DATA_W (DATA_W),
    .PHYS   (PHYS)
  ) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_idx    (phys[OPND_DST]),
    .wr_data   (wr_data),
    .rd_a_idx  (phys[OPND_SRC_A]),
    .rd_b_idx  (phys[OPND_SRC_B]),
    .rd_a_data (rd_a_data),
    .rd_b_data (rd_b_data)
  );

  assert_base_region_R2: assert property (@(posedge clk) disable iff (rst)
    specs[OPND_DST][SPEC_W-1] |-> (int'(phys[OPND_DST]) >= BANKED_TOTAL))
    else $error("base destination mapped into bank area");

  assert_bank_region_R2: assert property (@(posedge clk) disable iff (rst)
    !specs[OPND_SRC_A][SPEC_W-1] |-> (int'(phys[OPND_SRC_A]) < BANKED_TOTAL))
    else $error("banked source mapped outside bank area");

  assert_same_bank_R4: assert property (@(posedge clk) disable iff (rst)
    (!specs[OPND_DST][SPEC_W-1] && !specs[OPND_SRC_B][SPEC_W-1]) |->
      (phys[OPND_DST][PHYS_W-1:IDX_W] == phys[OPND_SRC_B][PHYS_W-1:IDX_W]))
    else $error("operands of one operation in different banks");

  assert_base_bank_free_R3: assert property (@(posedge clk) disable iff (rst)
    specs[OPND_SRC_A][SPEC_W-1] |->
      (phys[OPND_SRC_A][IDX_W-1:0] == specs[OPND_SRC_A][IDX_W-1:0]))
    else $error("base source index altered");
endmodule

// File: tb/sim_banked_rf.sv
module sim_banked_rf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        use_packed = 1'b0;
  logic [14:0] op_word = '0;
  logic [2:0]  bank_sel = '0;
  logic [3:0]  dst_spec = '0;
  logic [3:0]  src_a_spec = '0;
  logic [3:0]  src_b_spec = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_a_data, rd_b_data;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] model [72];

  always #2.5 clk = ~clk;

  banked_rf u0 (
    .clk(clk), .rst(rst), .use_packed(use_packed), .op_word(op_word),
    .bank_sel(bank_sel), .dst_spec(dst_spec), .src_a_spec(src_a_spec),
    .src_b_spec(src_b_spec), .wr_en(wr_en), .wr_data(wr_data),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data)
  );

  function automatic int phys_of(input logic [2:0] b, input logic [3:0] s);
    return s[3] ? (64 + int'(s[2:0])) : (int'(b) * 8 + int'(s[2:0]));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one operation: drive at negedge, check combinational reads, then commit
  task automatic op(input string tag, input bit pk, input logic [2:0] b,
                    input logic [3:0] d, input logic [3:0] a, input logic [3:0] s,
                    input bit we, input logic [31:0] data);
    @(negedge clk);
    use_packed = pk;
    wr_en = we;
    wr_data = data;
    if (pk) begin
      op_word = {b, d, a, s};
      bank_sel = 3'($urandom);
      dst_spec = 4'($urandom);
      src_a_spec = 4'($urandom);
      src_b_spec = 4'($urandom);
    end else begin
      op_word = 15'($urandom);
      bank_sel = b; dst_spec = d; src_a_spec = a; src_b_spec = s;
    end
    #1;
    check({tag, " port A"}, rd_a_data, model[phys_of(b, a)]);
    check({tag, " port B"}, rd_b_data, model[phys_of(b, s)]);
    @(posedge clk);
    if (we) model[phys_of(b, d)] = data;
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 72; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: all registers zero after reset
    for (int b = 0; b < 8; b++)
      for (int i = 0; i < 8; i++)
        op("R1 reset", 0, 3'(b), 4'h0, 4'(i), 4'(8 + i), 0, '0);

    // R2 R5: fill every bank register and every base register
    for (int b = 0; b < 8; b++)
      for (int i = 0; i < 8; i++)
        op("R2 fill bank", 0, 3'(b), 4'(i), 4'(i), 4'h8, 1, 32'hA000_0000 | 32'(b*8+i));
    for (int i = 0; i < 8; i++)
      op("R2 fill base", 0, 3'(i), 4'(8 + i), 4'h0, 4'(8 + i), 1, 32'hB000_0000 | 32'(i));
    for (int b = 0; b < 8; b++)
      for (int i = 0; i < 8; i++)
        op("R2 readback", 0, 3'(b), 4'h0, 4'(i), 4'(8 + (i ^ b) % 8), 0, '0);

    // R3: cross-bank transfer through base register 5
    op("R3 xfer out", 0, 3'd2, 4'hD, 4'h3, 4'h3, 1, model[phys_of(3'd2, 4'h3)]);
    op("R3 xfer in", 0, 3'd6, 4'h1, 4'hD, 4'hD, 1, model[phys_of(3'd6, 4'hD)]);
    op("R3 xfer check", 0, 3'd6, 4'h0, 4'h1, 4'hD, 0, '0);
    check("R3 value moved", model[6*8+1], 32'hA000_0013);

    // R6: same-cycle read of written register sees old value
    op("R6 write", 0, 3'd4, 4'h2, 4'h2, 4'h2, 1, 32'h1234_5678);
    op("R6 after", 0, 3'd4, 4'h2, 4'h2, 4'h2, 0, '0);

    // R4: banked destination and source share the bank
    op("R4 write", 0, 3'd7, 4'h6, 4'h6, 4'hE, 1, 32'hCAFE_0007);
    op("R4 read", 0, 3'd7, 4'h0, 4'h6, 4'h6, 0, '0);
    op("R4 other bank", 0, 3'd1, 4'h0, 4'h6, 4'h6, 0, '0);

    // R5: write enable low leaves register unchanged
    op("R5 no write", 0, 3'd0, 4'h0, 4'h0, 4'h0, 0, 32'hDEAD_BEEF);
    op("R5 hold", 0, 3'd0, 4'h0, 4'h0, 4'h0, 0, '0);

    // R7: packed operands override separate pins
    op("R7 packed write", 1, 3'd5, 4'hB, 4'h4, 4'hB, 1, 32'h0BAD_F00D);
    op("R7 packed read", 1, 3'd3, 4'h0, 4'hB, 4'h4, 0, '0);

    // R8: both ports on same register
    op("R8 same reg", 0, 3'd5, 4'h0, 4'h4, 4'h4, 0, '0);

    // random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 3000; k++) begin
      v = $urandom;
      op("R2 R7 random", bit'($urandom % 2), 3'($urandom), 4'($urandom),
         4'($urandom), 4'($urandom), bit'($urandom % 2), v);
    end

    // R1: reset again after activity
    @(negedge clk) rst = 1'b1; wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 72; i++) model[i] = '0;
    for (int b = 0; b < 8; b++)
      for (int i = 0; i < 8; i++)
        op("R1 re-reset", 0, 3'(b), 4'h0, 4'(i), 4'(8 + i), 0, '0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule